// File: doc/BRIEF.md
# Multi-Page-Size Translation Lookaside Buffer

This block is a fully associative translation buffer that turns 64-bit virtual addresses into 41-bit physical addresses. Each of its entries stores a virtual tag, a 13-bit context and a physical frame, together with a set of attributes:

- valid
- page size, one of 8 KiB, 64 KiB, 512 KiB or 4 MiB
- global
- privileged
- writable
- side-effect
- no-fault-only
- used

Software fills entries through a write port. A lookup compares the request against all entries in parallel, using the page size of each entry. Global entries ignore the context.

A lookup gives one of four outcomes one cycle later:

- a translated address
- a miss
- an access fault, from privilege or from no-fault rules
- a write-protection fault

A fault loads the fault status and fault address registers. A miss or any fault loads a tag-access register, which a refill handler reads. A clean hit marks the entry as used. When translation is off, the address passes through truncated to 41 bits.

Top module: `xlate_tlb`

## Requirements
- R1: After reset all entries are invalid, so an enabled lookup misses. The response outputs, status fields, fault address, tag-access and used bits are all zero.
- R2: An entry's page-size code s (0..3) makes its compare ignore virtual address bits below 13+3s. An address one byte past the page end misses.
- R3: The lookup context comes from `req_ctx_sel`: 0 selects `pri_ctx`, 1 selects `sec_ctx`, and 2 or 3 select 0. An entry matches only if its context equals the lookup context or its global bit is set.
- R4: On a hit, physical address bits 40 down to the page shift come from the entry frame. The bits below come from the virtual address, so bits 12:0 are always the virtual bits 12:0.
- R5: When several entries match, the lowest-numbered one supplies the result.
- R6: `rsp_ftype` bit 0 flags a privileged entry hit with `req_user`=1. Bit 1 flags a side-effect entry hit with `req_nofault`=1. Bit 2 flags a no-fault-only entry hit with `req_nofault`=0. Any set bit gives `rsp_fault`, and several bits can be set at once.
- R7: A store (`req_write`=1) that hits a non-writable entry with no access fault gives `rsp_prot`. An access fault takes precedence over protection.
- R8: On an access fault or a protection fault, the following is recorded:
  - `fsr_valid` becomes 1.
  - `fsr_ovf` takes the previous value of `fsr_valid`.
  - `fsr_ctx_src`, `fsr_write` and `fsr_ftype` record the request; `fsr_ftype` is 0 on a protection fault.
  - `far` captures the virtual address.
  - `fsr_clr` zeroes all status fields before a same-cycle fault is applied.
  - A miss leaves the status unchanged.
- R9: A miss or any fault loads `tag_acc` with the virtual address with bits 12:0 cleared, ORed with the lookup context.
- R10: A clean hit sets the entry's used bit, which `rd_used` shows for the entry at `rd_idx`. Writing an entry clears its used bit, and a write overrides a same-cycle used-bit set.
- R11: With `xlate_en`=0, every request is a hit with `rsp_pa` equal to the low 41 address bits. No fault, no status change, no tag-access load and no used-bit change occurs.
- R12: Results appear on the response outputs in the cycle after the request. At most one of hit, miss, fault and prot is set, and all response outputs are zero without a request. A lookup in the same cycle as an entry write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | 6 | Entry index to write |
| wr_va | input | 64 | Virtual tag |
| wr_ctx | input | 13 | Entry context |
| wr_pa | input | 41 | Physical frame address |
| wr_valid | input | 1 | Entry valid |
| wr_size | input | 2 | Page size code |
| wr_global | input | 1 | Ignore context on compare |
| wr_priv | input | 1 | Privileged-only entry |
| wr_writable | input | 1 | Stores permitted |
| wr_side_eff | input | 1 | Side-effect page |
| wr_nfo_only | input | 1 | No-fault accesses only |
| xlate_en | input | 1 | Translation enable |
| req_valid | input | 1 | Lookup request |
| req_va | input | 64 | Virtual address |
| req_ctx_sel | input | 2 | Context source select |
| req_write | input | 1 | Store access |
| req_nofault | input | 1 | No-fault access |
| req_user | input | 1 | User-mode access |
| pri_ctx | input | 13 | Primary context |
| sec_ctx | input | 13 | Secondary context |
| fsr_clr | input | 1 | Clear fault status |
| rd_idx | input | 6 | Entry whose used bit is shown |
| rd_used | output | 1 | Used bit of entry `rd_idx` |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No entry matched |
| rsp_fault | output | 1 | Access fault |
| rsp_prot | output | 1 | Write-protection fault |
| rsp_pa | output | 41 | Physical address |
| rsp_ftype | output | 3 | Access fault type bits |
| fsr_valid | output | 1 | Fault status valid |
| fsr_ovf | output | 1 | Fault overwritten before clear |
| fsr_ctx_src | output | 2 | Context source of last fault |
| fsr_write | output | 1 | Last fault was a store |
| fsr_ftype | output | 3 | Fault type bits of last fault |
| far | output | 64 | Fault virtual address |
| tag_acc | output | 64 | Tag-access value for refill |

## Verification
A corrupted entry field shows up as a wrong physical address, a false miss or a wrong fault type on the first lookup that touches that page. That response appears one cycle after the request. A lost or stuck used bit is visible on `rd_used` in the cycle after the hit or write. A wrong status, fault address or tag-access update is visible on those ports one cycle after the faulting or missing request. The bench's reference model compares every output on every clock, so any divergence is caught in the cycle it first reaches a port.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;

    // smallest page is 8 KiB, each size step multiplies by 8
    localparam int PAGE_SHIFT = 13;
    localparam int SIZE_STEP  = 3;

    // fault type bit positions
    localparam int FT_PRIV = 0;
    localparam int FT_SE   = 1;
    localparam int FT_NFO  = 2;

    typedef enum logic [1:0] {
        CTX_PRI = 2'd0,
        CTX_SEC = 2'd1,
        CTX_NUC = 2'd2,
        CTX_ALT = 2'd3
    } ctx_sel_e;

    typedef struct packed {
        logic       valid;
        logic [1:0] size;
        logic       glob;
        logic       priv;
        logic       wr_ok;
        logic       side_eff;
        logic       nfo;
    } xtlb_attr_t;

endpackage

// File: rtl/xtlb_store.sv
module xtlb_store
    import xtlb_pkg::*;
#(
    parameter int N_ENT = 64,
    parameter int VA_W  = 64,
    parameter int PA_W  = 41,
    parameter int CTX_W = 13,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VA_W-1:0]  wr_va,
    input  logic [CTX_W-1:0] wr_ctx,
    input  logic [PA_W-1:0]  wr_pa,
    input  xtlb_attr_t       wr_attr,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VA_W-1:0]  ent_va   [N_ENT],
    output logic [CTX_W-1:0] ent_ctx  [N_ENT],
    output logic [PA_W-1:0]  ent_pa   [N_ENT],
    output xtlb_attr_t       ent_attr [N_ENT],
    output logic             rd_used
);

    typedef struct packed {
        logic [VA_W-1:0]  va;
        logic [CTX_W-1:0] ctx;
        logic [PA_W-1:0]  pa;
        xtlb_attr_t       attr;
    } ent_t;

    ent_t             ent_q [N_ENT];
    ent_t             ent_d [N_ENT];
    logic [N_ENT-1:0] used_q;
    logic [N_ENT-1:0] used_d;

    always_comb begin
        ent_d  = ent_q;
        used_d = used_q;
        if (upd_en) begin
            used_d[upd_idx] = 1'b1;
        end
        if (wr_en) begin
            ent_d[wr_idx].va   = wr_va;
            ent_d[wr_idx].ctx  = wr_ctx;
            ent_d[wr_idx].pa   = wr_pa;
            ent_d[wr_idx].attr = wr_attr;
            used_d[wr_idx]     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) begin
                ent_q[i] <= '0;
            end
            used_q <= '0;
        end else begin
            ent_q  <= ent_d;
            used_q <= used_d;
        end
    end

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_out
        assign ent_va[gi]   = ent_q[gi].va;
        assign ent_ctx[gi]  = ent_q[gi].ctx;
        assign ent_pa[gi]   = ent_q[gi].pa;
        assign ent_attr[gi] = ent_q[gi].attr;
    end

    assign rd_used = used_q[rd_idx];

    // R10: a clean hit leaves the used bit set unless a write hit the same slot
    p_used_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && !(wr_en && wr_idx == upd_idx) |=> used_q[$past(upd_idx)]);

    // R10: writing an entry clears its used bit
    p_write_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !used_q[$past(wr_idx)]);

endmodule

// File: rtl/xtlb_match.sv
module xtlb_match
    import xtlb_pkg::*;
#(
    parameter int N_ENT = 64,
    parameter int VA_W  = 64,
    parameter int PA_W  = 41,
    parameter int CTX_W = 13,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic [VA_W-1:0]  va,
    input  logic [CTX_W-1:0] ctx,
    input  logic [VA_W-1:0]  ent_va   [N_ENT],
    input  logic [CTX_W-1:0] ent_ctx  [N_ENT],
    input  logic [PA_W-1:0]  ent_pa   [N_ENT],
    input  xtlb_attr_t       ent_attr [N_ENT],
    output logic             hit_any,
    output logic [IDX_W-1:0] hit_idx,
    output logic             hit_priv,
    output logic             hit_wr_ok,
    output logic             hit_side_eff,
    output logic             hit_nfo,
    output logic [PA_W-1:0]  hit_pa
);

    logic [N_ENT-1:0] match_vec;
    logic [VA_W-1:0]  mask_e [N_ENT];
    logic [PA_W-1:0]  pmask;

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_cmp
        assign mask_e[gi] = {VA_W{1'b1}} << (PAGE_SHIFT + SIZE_STEP * int'(ent_attr[gi].size));
        assign match_vec[gi] = ent_attr[gi].valid
                             && (((va ^ ent_va[gi]) & mask_e[gi]) == '0)
                             && (ent_attr[gi].glob || ent_ctx[gi] == ctx);
    end

    // scan from the top so the lowest matching index is the last to overwrite
    always_comb begin
        hit_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        hit_any      = |match_vec;
        hit_priv     = ent_attr[hit_idx].priv;
        hit_wr_ok    = ent_attr[hit_idx].wr_ok;
        hit_side_eff = ent_attr[hit_idx].side_eff;
        hit_nfo      = ent_attr[hit_idx].nfo;
        pmask        = mask_e[hit_idx][PA_W-1:0];
        hit_pa       = (ent_pa[hit_idx] & pmask) | (va[PA_W-1:0] & ~pmask);
    end

    // R5: the chosen entry matches and no lower-numbered entry does
    always_comb begin
        if (hit_any) begin
            p_first_hit_r5: assert (match_vec[hit_idx]
                && ((match_vec & ((N_ENT'(1) << hit_idx) - N_ENT'(1))) == '0));
        end
    end

endmodule

// File: rtl/xtlb_status.sv
module xtlb_status #(
    parameter int VA_W  = 64,
    parameter int CTX_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             flt_ev,
    input  logic             miss_ev,
    input  logic [VA_W-1:0]  va,
    input  logic [CTX_W-1:0] ctx,
    input  logic [1:0]       ctx_src,
    input  logic             is_write,
    input  logic [2:0]       ftype,
    output logic             fsr_valid,
    output logic             fsr_ovf,
    output logic [1:0]       fsr_ctx_src,
    output logic             fsr_write,
    output logic [2:0]       fsr_ftype,
    output logic [VA_W-1:0]  far,
    output logic [VA_W-1:0]  tag_acc
);

    localparam int LOW_W = 13;

    typedef struct packed {
        logic            valid;
        logic            ovf;
        logic [1:0]      src;
        logic            wr;
        logic [2:0]      ft;
        logic [VA_W-1:0] far;
        logic [VA_W-1:0] tag;
    } st_t;

    st_t st_q;
    st_t st_d;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.valid = 1'b0;
            st_d.ovf   = 1'b0;
            st_d.src   = '0;
            st_d.wr    = 1'b0;
            st_d.ft    = '0;
        end
        if (flt_ev) begin
            st_d.ovf   = st_q.valid && !clr;
            st_d.valid = 1'b1;
            st_d.src   = ctx_src;
            st_d.wr    = is_write;
            st_d.ft    = ftype;
            st_d.far   = va;
        end
        if (flt_ev || miss_ev) begin
            st_d.tag = {va[VA_W-1:LOW_W], {LOW_W{1'b0}}} | VA_W'(ctx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fsr_valid   = st_q.valid;
    assign fsr_ovf     = st_q.ovf;
    assign fsr_ctx_src = st_q.src;
    assign fsr_write   = st_q.wr;
    assign fsr_ftype   = st_q.ft;
    assign far         = st_q.far;
    assign tag_acc     = st_q.tag;

    // R8: every fault leaves the status marked valid
    p_fault_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flt_ev |=> fsr_valid);

    // R8: a fault on top of an unread status raises overflow
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flt_ev && fsr_valid && !clr |=> fsr_ovf);

    // R8: a plain miss does not disturb the status
    p_miss_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        miss_ev && !flt_ev && !clr |=> $stable(fsr_valid) && $stable(far));

    // R9: tag-access carries the lookup context after a miss or fault
    p_tag_ctx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flt_ev || miss_ev |=> tag_acc[CTX_W-1:0] == $past(ctx));

endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
    import xtlb_pkg::*;
#(
    parameter int N_ENT = 64,
    parameter int VA_W  = 64,
    parameter int PA_W  = 41,
    parameter int CTX_W = 13,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VA_W-1:0]  wr_va,
    input  logic [CTX_W-1:0] wr_ctx,
    input  logic [PA_W-1:0]  wr_pa,
    input  logic             wr_valid,
    input  logic [1:0]       wr_size,
    input  logic             wr_global,
    input  logic             wr_priv,
    input  logic             wr_writable,
    input  logic             wr_side_eff,
    input  logic             wr_nfo_only,
    input  logic             xlate_en,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic [1:0]       req_ctx_sel,
    input  logic             req_write,
    input  logic             req_nofault,
    input  logic             req_user,
    input  logic [CTX_W-1:0] pri_ctx,
    input  logic [CTX_W-1:0] sec_ctx,
    input  logic             fsr_clr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_used,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic             rsp_prot,
    output logic [PA_W-1:0]  rsp_pa,
    output logic [2:0]       rsp_ftype,
    output logic             fsr_valid,
    output logic             fsr_ovf,
    output logic [1:0]       fsr_ctx_src,
    output logic             fsr_write,
    output logic [2:0]       fsr_ftype,
    output logic [VA_W-1:0]  far,
    output logic [VA_W-1:0]  tag_acc
);

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            miss;
        logic            fault;
        logic            prot;
        logic [PA_W-1:0] pa;
        logic [2:0]      ft;
    } rsp_t;

    rsp_t rsp_q;
    rsp_t rsp_d;

    logic [VA_W-1:0]  ent_va   [N_ENT];
    logic [CTX_W-1:0] ent_ctx  [N_ENT];
    logic [PA_W-1:0]  ent_pa   [N_ENT];
    xtlb_attr_t       ent_attr [N_ENT];
    xtlb_attr_t       wr_attr;

    logic [CTX_W-1:0] lk_ctx;
    logic             hit_any;
    logic [IDX_W-1:0] hit_idx;
    logic             hit_priv;
    logic             hit_wr_ok;
    logic             hit_side_eff;
    logic             hit_nfo;
    logic [PA_W-1:0]  hit_pa;
    logic [2:0]       ft;
    logic             acc_flt;
    logic             prot_flt;
    logic             clean;
    logic             active;
    logic             upd_en;
    logic             flt_ev;
    logic             miss_ev;

    assign wr_attr = '{valid: wr_valid, size: wr_size, glob: wr_global, priv: wr_priv,
                       wr_ok: wr_writable, side_eff: wr_side_eff, nfo: wr_nfo_only};

    always_comb begin
        unique case (ctx_sel_e'(req_ctx_sel))
            CTX_PRI: lk_ctx = pri_ctx;
            CTX_SEC: lk_ctx = sec_ctx;
            default: lk_ctx = '0;
        endcase
    end

    xtlb_store #(.N_ENT(N_ENT), .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_va    (wr_va),
        .wr_ctx   (wr_ctx),
        .wr_pa    (wr_pa),
        .wr_attr  (wr_attr),
        .upd_en   (upd_en),
        .upd_idx  (hit_idx),
        .rd_idx   (rd_idx),
        .ent_va   (ent_va),
        .ent_ctx  (ent_ctx),
        .ent_pa   (ent_pa),
        .ent_attr (ent_attr),
        .rd_used  (rd_used)
    );

    xtlb_match #(.N_ENT(N_ENT), .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W)) i_match (
        .va           (req_va),
        .ctx          (lk_ctx),
        .ent_va       (ent_va),
        .ent_ctx      (ent_ctx),
        .ent_pa       (ent_pa),
        .ent_attr     (ent_attr),
        .hit_any      (hit_any),
        .hit_idx      (hit_idx),
        .hit_priv     (hit_priv),
        .hit_wr_ok    (hit_wr_ok),
        .hit_side_eff (hit_side_eff),
        .hit_nfo      (hit_nfo),
        .hit_pa       (hit_pa)
    );

    always_comb begin
        ft           = '0;
        ft[FT_PRIV]  = hit_priv && req_user;
        ft[FT_SE]    = hit_side_eff && req_nofault;
        ft[FT_NFO]   = hit_nfo && !req_nofault;
        active       = req_valid && xlate_en;
        acc_flt      = hit_any && (ft != '0);
        prot_flt     = hit_any && !acc_flt && req_write && !hit_wr_ok;
        clean        = hit_any && !acc_flt && !prot_flt;
        upd_en       = active && clean;
        flt_ev       = active && (acc_flt || prot_flt);
        miss_ev      = active && !hit_any;

        rsp_d        = '0;
        rsp_d.valid  = req_valid;
        if (req_valid && !xlate_en) begin
            rsp_d.hit = 1'b1;
            rsp_d.pa  = req_va[PA_W-1:0];
        end else if (active) begin
            rsp_d.hit   = clean;
            rsp_d.miss  = !hit_any;
            rsp_d.fault = acc_flt;
            rsp_d.prot  = prot_flt;
            rsp_d.pa    = clean ? hit_pa : '0;
            rsp_d.ft    = acc_flt ? ft : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    xtlb_status #(.VA_W(VA_W), .CTX_W(CTX_W)) i_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (fsr_clr),
        .flt_ev      (flt_ev),
        .miss_ev     (miss_ev),
        .va          (req_va),
        .ctx         (lk_ctx),
        .ctx_src     (req_ctx_sel),
        .is_write    (req_write),
        .ftype       (acc_flt ? ft : 3'b000),
        .fsr_valid   (fsr_valid),
        .fsr_ovf     (fsr_ovf),
        .fsr_ctx_src (fsr_ctx_src),
        .fsr_write   (fsr_write),
        .fsr_ftype   (fsr_ftype),
        .far         (far),
        .tag_acc     (tag_acc)
    );

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_miss  = rsp_q.miss;
    assign rsp_fault = rsp_q.fault;
    assign rsp_prot  = rsp_q.prot;
    assign rsp_pa    = rsp_q.pa;
    assign rsp_ftype = rsp_q.ft;

    // R12: exactly one outcome per response, none without a request
    p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_miss, rsp_fault, rsp_prot})
        && (rsp_valid == (rsp_hit || rsp_miss || rsp_fault || rsp_prot)));

    // R11: with translation off the address passes through one cycle later
    p_passthru_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !xlate_en |=> rsp_hit && rsp_pa == $past(req_va[PA_W-1:0]));

    // R11: with translation off the status never changes
    p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !xlate_en && !fsr_clr |=> $stable(fsr_valid) && $stable(tag_acc));

    // R7: protection faults only come from stores
    p_prot_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> !rsp_prot);

endmodule

// File: tb/test_xlate_tlb.sv
module test_xlate_tlb;

    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_va = '0;
    logic [12:0] wr_ctx = '0;
    logic [40:0] wr_pa = '0;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_size = '0;
    logic        wr_global = 1'b0, wr_priv = 1'b0, wr_writable = 1'b0;
    logic        wr_side_eff = 1'b0, wr_nfo_only = 1'b0;
    logic        xlate_en = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic [1:0]  req_ctx_sel = '0;
    logic        req_write = 1'b0, req_nofault = 1'b0, req_user = 1'b0;
    logic [12:0] pri_ctx = 13'd5, sec_ctx = 13'd5;
    logic        fsr_clr = 1'b0;
    logic [5:0]  rd_idx = '0;
    logic        rd_used;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_prot;
    logic [40:0] rsp_pa;
    logic [2:0]  rsp_ftype;
    logic        fsr_valid, fsr_ovf, fsr_write;
    logic [1:0]  fsr_ctx_src;
    logic [2:0]  fsr_ftype;
    logic [63:0] far, tag_acc;

    xlate_tlb i_xlate_tlb (.*);

    always #5 clk = ~clk;

    // reference model state
    logic [63:0] m_va [N];
    logic [12:0] m_ctx [N];
    logic [40:0] m_pa [N];
    bit          m_v [N], m_g [N], m_p [N], m_w [N], m_se [N], m_nfo [N], m_used [N];
    int unsigned m_sz [N];
    bit          s_valid, s_ovf, s_wr;
    logic [1:0]  s_src;
    logic [2:0]  s_ft;
    logic [63:0] s_far, s_tag;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input string nm, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
        end
    endtask

    task automatic tick(input string tag);
        bit          e_v, e_h, e_m, e_f, e_pr, found, clean;
        logic [40:0] e_pa;
        logic [2:0]  e_ft;
        logic [63:0] pa64;
        logic [12:0] ctx;
        int          idx, lb;
        e_v = 0; e_h = 0; e_m = 0; e_f = 0; e_pr = 0; e_pa = '0; e_ft = '0;
        found = 0; idx = 0; clean = 0;
        ctx = (req_ctx_sel == 2'd0) ? pri_ctx : (req_ctx_sel == 2'd1) ? sec_ctx : 13'd0;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_v[i] = 0; m_used[i] = 0; m_va[i] = '0; m_ctx[i] = '0; m_pa[i] = '0;
                m_sz[i] = 0; m_g[i] = 0; m_p[i] = 0; m_w[i] = 0; m_se[i] = 0; m_nfo[i] = 0;
            end
            s_valid = 0; s_ovf = 0; s_wr = 0; s_src = '0; s_ft = '0; s_far = '0; s_tag = '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                lb = 13 + 3 * m_sz[i];
                if (!found && m_v[i] && ((req_va >> lb) == (m_va[i] >> lb))
                    && (m_g[i] || m_ctx[i] == ctx)) begin
                    found = 1;
                    idx = i;
                end
            end
            if (req_valid) begin
                e_v = 1;
                if (!xlate_en) begin
                    e_h = 1;
                    e_pa = req_va[40:0];
                end else if (!found) begin
                    e_m = 1;
                end else begin
                    e_ft = {m_nfo[idx] && !req_nofault, m_se[idx] && req_nofault, m_p[idx] && req_user};
                    if (e_ft != 0) e_f = 1;
                    else if (req_write && !m_w[idx]) e_pr = 1;
                    else begin
                        e_h = 1;
                        clean = 1;
                        lb = 13 + 3 * m_sz[idx];
                        pa64 = (({23'd0, m_pa[idx]} >> lb) << lb) | (req_va & ((64'd1 << lb) - 64'd1));
                        e_pa = pa64[40:0];
                    end
                end
            end
            if (fsr_clr) begin
                s_valid = 0; s_ovf = 0; s_wr = 0; s_src = '0; s_ft = '0;
            end
            if (e_f || e_pr) begin
                s_ovf = s_valid;
                s_valid = 1;
                s_src = req_ctx_sel;
                s_wr = req_write;
                s_ft = e_f ? e_ft : 3'b000;
                s_far = req_va;
            end
            if (e_m || e_f || e_pr) s_tag = {req_va[63:13], 13'd0} | {51'd0, ctx};
            if (clean) m_used[idx] = 1;
            if (wr_en) begin
                m_va[wr_idx] = wr_va; m_ctx[wr_idx] = wr_ctx; m_pa[wr_idx] = wr_pa;
                m_v[wr_idx] = wr_valid; m_sz[wr_idx] = wr_size; m_g[wr_idx] = wr_global;
                m_p[wr_idx] = wr_priv; m_w[wr_idx] = wr_writable; m_se[wr_idx] = wr_side_eff;
                m_nfo[wr_idx] = wr_nfo_only; m_used[wr_idx] = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(tag, "rsp_valid", 64'(rsp_valid), 64'(e_v));
        chk(tag, "outcome", 64'({rsp_hit, rsp_miss, rsp_fault, rsp_prot}), 64'({e_h, e_m, e_f, e_pr}));
        chk(tag, "rsp_pa", 64'(rsp_pa), 64'(e_pa));
        chk(tag, "rsp_ftype", 64'(rsp_ftype), 64'(e_ft));
        chk(tag, "status", 64'({fsr_valid, fsr_ovf, fsr_ctx_src, fsr_write, fsr_ftype}),
            64'({s_valid, s_ovf, s_src, s_wr, s_ft}));
        chk(tag, "far", far, s_far);
        chk(tag, "tag_acc", tag_acc, s_tag);
        chk(tag, "rd_used", 64'(rd_used), 64'(m_used[rd_idx]));
    endtask

    task automatic put(input int idx, input logic [63:0] va, input logic [12:0] ctx, input logic [63:0] pa,
                       input int sz, input bit g, input bit p, input bit w, input bit se, input bit nfo,
                       input string tag);
        wr_en = 1; wr_idx = 6'(idx); wr_va = va; wr_ctx = ctx; wr_pa = pa[40:0]; wr_valid = 1;
        wr_size = 2'(sz); wr_global = g; wr_priv = p; wr_writable = w; wr_side_eff = se; wr_nfo_only = nfo;
        tick(tag);
        wr_en = 0;
    endtask

    task automatic look(input logic [63:0] va, input int sel, input bit w, input bit nf, input bit u,
                        input string tag);
        req_valid = 1; req_va = va; req_ctx_sel = 2'(sel); req_write = w; req_nofault = nf; req_user = u;
        tick(tag);
        req_valid = 0; req_write = 0; req_nofault = 0; req_user = 0;
    endtask

    initial begin
        tick("R1");
        tick("R1");
        rst_n = 1;
        tick("R1");
        look(64'h0000_0012_3456_6000, 0, 0, 0, 0, "R1");

        // R2/R4 page sizes
        put(0, 64'h0000_0012_3456_6000, 13'd5, 64'h0000_0155_5555_4000, 0, 0, 0, 1, 0, 0, "R2");
        put(1, 64'hFFFF_8000_0001_0000, 13'd5, 64'h0000_01AB_CDE3_0000, 1, 0, 0, 1, 0, 0, "R2");
        put(2, 64'h0000_4000_0008_0000, 13'd7, 64'h0000_0077_7770_0000, 2, 0, 0, 1, 0, 0, "R2");
        put(3, 64'h0000_0000_0040_0000, 13'd9, 64'h0000_01FF_FFC0_0000, 3, 1, 0, 1, 0, 0, "R3");
        rd_idx = 0;
        look(64'h0000_0012_3456_7ABC, 0, 0, 0, 0, "R4");
        look(64'h0000_0012_3456_8000, 0, 0, 0, 0, "R2");
        rd_idx = 1;
        look(64'hFFFF_8000_0001_FFFF, 0, 1, 0, 0, "R4");
        look(64'hFFFF_8000_0002_0000, 0, 0, 0, 0, "R2");
        sec_ctx = 13'd7;
        look(64'h0000_4000_000F_FFFF, 1, 0, 0, 0, "R2");
        look(64'h0000_4000_0010_0000, 1, 0, 0, 0, "R2");
        look(64'h0000_0000_007F_FFFF, 2, 0, 0, 0, "R3");
        look(64'h0000_0000_007F_0001, 3, 0, 0, 0, "R3");
        look(64'h0000_0012_3456_6004, 1, 0, 0, 0, "R3");
        sec_ctx = 13'd5;
        look(64'h0000_0012_3456_6004, 1, 0, 0, 0, "R3");
        look(64'h0000_0012_3456_6004, 2, 0, 0, 0, "R3");

        // R5 lowest index wins; non-matching context ignored
        put(20, 64'h0000_0000_2000_0000, 13'd5, 64'h0000_0011_1111_0000, 0, 0, 0, 1, 0, 0, "R5");
        put(30, 64'h0000_0000_2000_0000, 13'd6, 64'h0000_0033_3333_0000, 0, 0, 0, 1, 0, 0, "R5");
        put(10, 64'h0000_0000_2000_0000, 13'd5, 64'h0000_0022_2222_0000, 0, 0, 0, 1, 0, 0, "R5");
        rd_idx = 10;
        look(64'h0000_0000_2000_0123, 0, 0, 0, 0, "R5");
        rd_idx = 20;
        look(64'h0000_0000_2000_0123, 0, 0, 0, 0, "R5");
        pri_ctx = 13'd6;
        rd_idx = 30;
        look(64'h0000_0000_2000_0123, 0, 0, 0, 0, "R5");
        pri_ctx = 13'd5;

        // R6 access faults, R7 protection
        put(4, 64'h0000_0000_1000_0000, 13'd5, 64'h0000_0001_0000_0000, 0, 0, 1, 1, 0, 0, "R6");
        put(5, 64'h0000_0000_1000_2000, 13'd5, 64'h0000_0001_0000_2000, 0, 0, 0, 1, 1, 0, "R6");
        put(6, 64'h0000_0000_1000_4000, 13'd5, 64'h0000_0001_0000_4000, 0, 0, 0, 1, 0, 1, "R6");
        put(7, 64'h0000_0000_1000_6000, 13'd5, 64'h0000_0001_0000_6000, 0, 0, 0, 0, 0, 0, "R7");
        put(8, 64'h0000_0000_1000_8000, 13'd5, 64'h0000_0001_0000_8000, 0, 0, 1, 0, 1, 1, "R6");
        rd_idx = 4;
        look(64'h0000_0000_1000_0010, 0, 0, 0, 1, "R6");
        look(64'h0000_0000_1000_0010, 0, 0, 0, 0, "R6");
        fsr_clr = 1; tick("R8"); fsr_clr = 0;
        look(64'h0000_0000_1000_2010, 1, 0, 1, 0, "R6");
        look(64'h0000_0000_1000_2010, 0, 0, 0, 0, "R6");
        look(64'h0000_0000_1000_4010, 0, 0, 0, 0, "R6");
        look(64'h0000_0000_1000_4010, 0, 0, 1, 0, "R6");
        look(64'h0000_0000_1000_8010, 0, 0, 1, 1, "R6");
        look(64'h0000_0000_1000_8010, 0, 1, 0, 1, "R7");
        fsr_clr = 1; tick("R8"); fsr_clr = 0;
        rd_idx = 7;
        look(64'h0000_0000_1000_6020, 0, 1, 0, 0, "R7");
        look(64'h0000_0000_1000_6020, 0, 0, 0, 0, "R7");
        look(64'h0000_0000_1000_6020, 0, 1, 0, 0, "R8");
        look(64'h0000_0000_3333_0000, 0, 0, 0, 0, "R9");
        // clear together with a fault
        fsr_clr = 1;
        look(64'h0000_0000_1000_0040, 0, 0, 0, 1, "R8");
        fsr_clr = 0;
        look(64'hABCD_0000_0000_0000, 1, 0, 0, 0, "R9");

        // R10 used bits
        rd_idx = 0;
        look(64'h0000_0012_3456_6100, 0, 0, 0, 0, "R10");
        put(0, 64'h0000_0012_3456_6000, 13'd5, 64'h0000_0155_5555_4000, 0, 0, 0, 1, 0, 0, "R10");
        wr_en = 1; wr_idx = 0; wr_va = 64'h0000_0012_3456_6000;
        look(64'h0000_0012_3456_6100, 0, 0, 0, 0, "R10");
        wr_en = 0;
        tick("R10");

        // R12 same-cycle write sees old contents
        rd_idx = 40;
        wr_en = 1; wr_idx = 40; wr_va = 64'h0000_0000_5000_0000; wr_ctx = 13'd5;
        wr_pa = 41'h0_0005_5000_0000; wr_valid = 1; wr_size = 0; wr_global = 0;
        wr_priv = 0; wr_writable = 1; wr_side_eff = 0; wr_nfo_only = 0;
        look(64'h0000_0000_5000_0100, 0, 0, 0, 0, "R12");
        wr_en = 0;
        look(64'h0000_0000_5000_0100, 0, 0, 0, 0, "R12");
        tick("R12");

        // R11 translation off
        xlate_en = 0;
        rd_idx = 4;
        look(64'hFEDC_BA98_7654_3210, 0, 1, 0, 1, "R11");
        look(64'h0000_0000_1000_0010, 0, 0, 0, 1, "R11");
        look(64'h0000_0012_3456_8000, 0, 0, 0, 0, "R11");
        xlate_en = 1;
        tick("R11");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule